// File: doc/BRIEF.md
# Input Transition Detector with Deferred Interrupt

This block watches a small group of input pins on a serial port expander and reports which of them changed since the device was last accessed. It keeps a snapshot of the pins and one change flag per pin, and drives an active-low, latching interrupt. The serial slave engine outside the block tells it about bus events through single-cycle strobes: an access was acknowledged (with its direction), the next read byte is being loaded, a STOP was seen, or the bus was aborted by a hardware reset. In return the block presents the byte to be shifted out: the port data byte or the flag byte.

Every acknowledged access takes a new snapshot, hands the accumulated flags to the read path and clears them, and releases the interrupt. While a read is open the interrupt is held back so that an interrupt handler is not re-entered. At STOP it is raised only for changes that were not already returned by the read. Long reads keep returning data/flag pairs. Each new pair takes a fresh snapshot, so a change during a long read is never lost.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the interrupt output is high, and the first read returns a flag byte of zero whatever level the pins held during reset.
- R2: A pin whose synchronized level differs from its snapshot sets its own change flag. In the flag byte, bit i is pin i, and the bits above the pin count always read zero.
- R3: An access acknowledge of either direction copies the current pins into the snapshot and the pending flags into the returned flag byte, then clears the pending flags.
- R4: With no read open, a change on an enabled pin drives `irq_n_o` low within five clock edges. It stays low until the next access acknowledge, and is high on the cycle after that acknowledge.
- R5: `irq_en_i` bit i set to 1 lets pin i raise the interrupt. A pin whose bit is 0 still sets its flag but never drives `irq_n_o` low.
- R6: After a read acknowledge `rd_byte_o` shows the data byte (pins in bits 3:0, upper bits zero). Each `byte_next_i` during the read toggles between the data byte and the flag byte. The new byte is valid from the clock edge that takes the strobe.
- R7: In a read, each `byte_next_i` that moves from the flag byte back to the data byte takes a new snapshot and captures and clears the flags, as in R3.
- R8: While a read is open, `irq_n_o` does not fall. At STOP it falls if enabled pending flags remain that were not captured by the read.
- R9: A STOP after a read that captured every change leaves `irq_n_o` high.
- R10: `bus_abort_i` closes an open read as STOP does. It never releases an interrupt that is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NP | Asynchronous input pins |
| irq_en_i | input | NP | Interrupt enable per pin, 1 enables |
| acc_ack_i | input | 1 | Strobe: this device's address was acknowledged |
| acc_rd_i | input | 1 | Direction qualifying `acc_ack_i`, 1 is read |
| byte_next_i | input | 1 | Strobe: next read byte is being loaded |
| stop_i | input | 1 | Strobe: STOP condition seen |
| bus_abort_i | input | 1 | Strobe: hardware reset aborted the transaction |
| rd_byte_o | output | BW | Byte to transmit for the current read index |
| irq_n_o | output | 1 | Active-low latching interrupt |

## Verification
The hardest case to reach is a pin change that arrives inside an open read. Whether it raises the interrupt at STOP depends on whether a data/flag pair boundary was crossed after the change. The bench opens reads, moves pins at chosen byte indices, and closes the read with either a STOP or a bus abort, sometimes before the boundary and sometimes after it. It then checks both the interrupt and the flag byte returned on the next pair. A full sweep over old pin levels, new pin levels and enable masks covers flag and mask behaviour.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  typedef enum logic {
    SEL_DATA  = 1'b0,
    SEL_FLAGS = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int NP     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] pin_s_o
);
  logic [NP-1:0] st_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [NP-1:0] st_d;
    if (k == 0) begin : g_first
      assign st_d = pin_i;
    end else begin : g_rest
      assign st_d = st_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[k] <= '0;
      else        st_q[k] <= st_d;
    end
  end

  assign pin_s_o = st_q[STAGES-1];
endmodule

// File: rtl/chg_track.sv
module chg_track #(
  parameter int NP     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_s_i,
  input  logic          sample_i,
  output logic [NP-1:0] snap_o,
  output logic [NP-1:0] flags_o,
  output logic [NP-1:0] hold_o
);
  localparam int WARM = STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [CW-1:0] warm_q, warm_d;
  logic [NP-1:0] snap_q, snap_d;
  logic [NP-1:0] flags_q, flags_d;
  logic [NP-1:0] hold_q, hold_d;
  logic          warm_done, warm_en, snap_en;
  logic [NP-1:0] diff;

  assign warm_done = (warm_q == CW'(WARM));
  assign warm_en   = !warm_done;
  assign snap_en   = sample_i || !warm_done;
  assign diff      = pin_s_i ^ snap_q;

  always_comb begin
    warm_d  = warm_q + CW'(1);
    snap_d  = pin_s_i;
    flags_d = snap_en ? '0 : (flags_q | diff);
    if (sample_i)       hold_d = flags_q | diff;
    else if (!warm_done) hold_d = '0;
    else                hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q  <= '0;
      snap_q  <= '0;
      flags_q <= '0;
      hold_q  <= '0;
    end else begin
      if (warm_en) warm_q <= warm_d;
      if (snap_en) snap_q <= snap_d;
      flags_q <= flags_d;
      hold_q  <= hold_d;
    end
  end

  assign snap_o  = snap_q;
  assign flags_o = flags_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import pin_change_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_ack_i,
  input  logic          acc_rd_i,
  input  logic          byte_next_i,
  input  logic          stop_i,
  input  logic          bus_abort_i,
  input  logic [NP-1:0] flags_i,
  input  logic [NP-1:0] irq_en_i,
  output logic          rd_active_o,
  output byte_sel_e     sel_o,
  output logic          sample_o,
  output logic          irq_n_o
);
  logic      rd_q, rd_d;
  byte_sel_e sel_q, sel_d;
  logic      irq_q, irq_d;
  logic      advance, raise;

  assign advance  = rd_q && byte_next_i;
  assign sample_o = acc_ack_i || (advance && (sel_q == SEL_FLAGS));
  assign raise    = !rd_q && (|(flags_i & irq_en_i));

  always_comb begin
    if (acc_ack_i)                rd_d = acc_rd_i;
    else if (stop_i || bus_abort_i) rd_d = 1'b0;
    else                          rd_d = rd_q;

    if (acc_ack_i)    sel_d = SEL_DATA;
    else if (advance) sel_d = (sel_q == SEL_DATA) ? SEL_FLAGS : SEL_DATA;
    else              sel_d = sel_q;

    irq_d = acc_ack_i ? 1'b0 : (irq_q || raise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      sel_q <= SEL_DATA;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      sel_q <= sel_d;
      irq_q <= irq_d;
    end
  end

  assign rd_active_o = rd_q;
  assign sel_o       = sel_q;
  assign irq_n_o     = !irq_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_pkg::*;
#(
  parameter int NP     = 4,
  parameter int BW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_i,
  input  logic [NP-1:0] irq_en_i,
  input  logic          acc_ack_i,
  input  logic          acc_rd_i,
  input  logic          byte_next_i,
  input  logic          stop_i,
  input  logic          bus_abort_i,
  output logic [BW-1:0] rd_byte_o,
  output logic          irq_n_o
);
  logic          rst_m_q, rst_s_q;
  logic [NP-1:0] pin_s, snap_w, flags_w, hold_w;
  logic          rd_active_w, sample_w;
  byte_sel_e     sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  pin_sync #(.NP(NP), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .pin_i(pin_i), .pin_s_o(pin_s)
  );

  chg_track #(.NP(NP), .STAGES(STAGES)) u_track (
    .clk(clk), .rst_n(rst_s_q), .pin_s_i(pin_s), .sample_i(sample_w),
    .snap_o(snap_w), .flags_o(flags_w), .hold_o(hold_w)
  );

  irq_ctl #(.NP(NP)) u_irq (
    .clk(clk), .rst_n(rst_s_q),
    .acc_ack_i(acc_ack_i), .acc_rd_i(acc_rd_i), .byte_next_i(byte_next_i),
    .stop_i(stop_i), .bus_abort_i(bus_abort_i),
    .flags_i(flags_w), .irq_en_i(irq_en_i),
    .rd_active_o(rd_active_w), .sel_o(sel_w), .sample_o(sample_w),
    .irq_n_o(irq_n_o)
  );

  always_comb begin
    rd_byte_o = '0;
    rd_byte_o[NP-1:0] = (sel_w == SEL_FLAGS) ? hold_w : snap_w;
  end
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int NP = 4,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] irq_en_i,
  input logic          acc_ack_i,
  input logic          bus_abort_i,
  input logic [BW-1:0] rd_byte_o,
  input logic          irq_n_o,
  input logic [NP-1:0] flags,
  input logic          rd_active
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte_o[BW-1:NP] == '0); // R2

  AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack_i |=> irq_n_o); // R4

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past((|(flags & irq_en_i)) && !rd_active)); // R5

  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && irq_n_o) |=> irq_n_o); // R8

  AST_ABORT_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_abort_i && !acc_ack_i && !irq_n_o) |=> !irq_n_o); // R10
endmodule

bind pin_change_irq pin_change_irq_chk #(.NP(NP), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en_i(irq_en_i), .acc_ack_i(acc_ack_i),
  .bus_abort_i(bus_abort_i), .rd_byte_o(rd_byte_o), .irq_n_o(irq_n_o),
  .flags(flags_w), .rd_active(rd_active_w)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 190000;

  logic       clk, rst_n;
  logic [3:0] pin, en;
  logic       ack, rd, nxt, stp, abt;
  logic [7:0] rbyte;
  logic       irq_n;
  int         vec, bad;
  bit         done;

  pin_change_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en),
    .acc_ack_i(ack), .acc_rd_i(rd), .byte_next_i(nxt), .stop_i(stp),
    .bus_abort_i(abt), .rd_byte_o(rbyte), .irq_n_o(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic access(input logic dir);
    ack = 1'b1; rd = dir;
    cyc(1);
    ack = 1'b0; rd = 1'b0;
  endtask

  task automatic next_byte();
    nxt = 1'b1; cyc(1); nxt = 1'b0;
  endtask

  task automatic stop_ev();
    stp = 1'b1; cyc(1); stp = 1'b0;
  endtask

  task automatic abort_ev();
    abt = 1'b1; cyc(1); abt = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    cyc(WDOG);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    vec = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; pin = 4'b1010; en = 4'hF;
    ack = 0; rd = 0; nxt = 0; stp = 0; abt = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(10);
    // R1: reset state
    chk("R1 irq after reset", irq_n, 1);
    access(1'b1);
    chk("R1 data byte after reset", rbyte, 8'h0A);
    next_byte();
    chk("R1 flags after reset", rbyte, 0);
    stop_ev();

    // Sweep: old level x new level x enable mask
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        for (int m = 0; m < 16; m++) begin
          en = 4'(m);
          pin = 4'(o);
          cyc(5);
          access(1'b0); // R3: write access resamples and clears
          stop_ev();
          cyc(4);
          chk("R3 no irq after clearing access", irq_n, 1);
          pin = 4'(n);
          cyc(5);
          chk("R4 R5 irq after change", irq_n, ((o ^ n) & m) != 0 ? 0 : 1);
          access(1'b1);
          chk("R4 irq released by ack", irq_n, 1);
          chk("R6 data byte", rbyte, n);
          next_byte();
          chk("R2 R3 flag byte", rbyte, o ^ n);
          stop_ev();
          cyc(4);
          chk("R9 stop after captured change", irq_n, 1);
        end
      end
    end

    // R8: change during read deferred to STOP
    en = 4'hF; pin = 4'h0; cyc(5);
    access(1'b0); stop_ev();
    access(1'b1);
    pin = 4'h1; cyc(6);
    chk("R8 irq held during read", irq_n, 1);
    stop_ev(); cyc(2);
    chk("R8 irq raised at STOP", irq_n, 0);
    // R10: abort leaves asserted irq
    abort_ev(); cyc(2);
    chk("R10 abort keeps irq", irq_n, 0);
    access(1'b0);
    chk("R4 release by write ack", irq_n, 1);
    stop_ev(); cyc(2);

    // R7: long read resamples on pair boundary
    access(1'b1);
    next_byte();
    pin = 4'h9; cyc(6);
    chk("R8 irq held in long read", irq_n, 1);
    next_byte();
    chk("R7 resampled data byte", rbyte, 8'h09);
    next_byte();
    chk("R7 flag byte of second pair", rbyte, 8'h08);
    next_byte();
    chk("R7 third pair data", rbyte, 8'h09);
    next_byte();
    chk("R7 third pair flags clear", rbyte, 0);
    stop_ev(); cyc(4);
    chk("R9 no irq after reported change", irq_n, 1);

    // R10: abort closes read like STOP
    access(1'b1);
    pin = 4'h8; cyc(6);
    chk("R8 held before abort", irq_n, 1);
    abort_ev(); cyc(3);
    chk("R10 abort ends read, irq raised", irq_n, 0);
    access(1'b1);
    next_byte();
    chk("R10 flags kept across abort", rbyte, 8'h01);
    stop_ev(); cyc(3);

    // R5: masked change raises no irq even after STOP
    en = 4'h0; access(1'b1);
    pin = 4'h0; cyc(6);
    stop_ev(); cyc(4);
    chk("R5 masked change no irq", irq_n, 1);

    done = 1'b1;
    finish_run();
  end
endmodule